// File: doc/BRIEF.md
# Paged Scatter-Gather DMA Address Generator

This block produces the memory address for each byte of a byte-stream DMA channel between a disk-style peripheral and system memory. Software fills a table of page numbers, one per 4 KiB physical page of a buffer that is contiguous only in virtual space. It then writes a start register that holds the byte offset inside the first page and the transfer direction. Each time the peripheral moves a byte it raises an advance request. In that same cycle the block presents a 28-bit physical address and a valid strobe, and it then steps to the next byte.

The start offset is used only for the first page. When the in-page offset wraps, the engine takes the next table entry and begins that page at offset zero. If the transfer runs past the last entry, a sticky overrun flag stops the engine. A flush write of zero returns the engine to idle.

Top module: `sg_dma_addr_gen`

## Requirements
- R1: After reset, dma_valid, overrun, dma_dir and dma_addr are all zero. An advance request does not raise dma_valid, and every page entry reads back as zero.
- R2: A write to the start register at byte address 0x000 arms the engine at table index 0. Bit 15 of the write sets dma_dir (1 means peripheral to memory) and bits 11:0 set the first offset. The start register reads back bit 15 and bits 11:0, and bits 14:12 always read as zero.
- R3: Page entry n sits at byte address 0x400 + 4·n. It stores 16 bits and reads back exactly the value last written. A write to an address in that region that is not a multiple of 4 changes no entry.
- R4: dma_addr equals the current page entry shifted left by 12 bits, ORed with the 12-bit in-page offset.
- R5: dma_valid is high in exactly those cycles in which adv_req is high, the engine is armed and overrun is low. After each valid cycle the offset increases by one, and dma_addr does not change in cycles without a valid strobe.
- R6: When a valid byte sits at offset 0xFFF, the next address uses the following table entry at offset 0x000. The programmed start offset never applies to later pages.
- R7: The byte at offset 0xFFF of the last entry is still issued. After it, overrun goes high and stays high, dma_valid stays low for every further request, and dma_addr holds that last byte's address.
- R8: Writing zero to the flush register at byte address 0x004 disarms the engine, clears overrun and sets dma_addr to zero. Writing a nonzero value there has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | BUS_AW (12) | Register byte address |
| bus_wdata | input | DATA_W (32) | Register write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| adv_req | input | 1 | Peripheral requests the address of one byte |
| dma_valid | output | 1 | dma_addr is issued for this byte |
| dma_addr | output | ENTRY_W+OFFS_W (28) | Physical byte address |
| dma_dir | output | 1 | 1: peripheral to memory, 0: memory to peripheral |
| overrun | output | 1 | Sticky flag: the transfer ran past the table |

## Verification
A wrong offset counter shows up on dma_addr in the cycle after the first valid strobe, because every byte's address is compared. A wrong table index or page-base register stays hidden until an offset wrap, and then the upper 16 address bits are wrong on the very next byte. A wrong overrun or armed state appears the next time adv_req is raised, as a valid strobe that should not occur or one that is missing. The long run through every page of a reduced table exercises the index state at each wrap and at the final entry.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_START = 2'd1,
      SEL_FLUSH = 2'd2,
      SEL_PAGE  = 2'd3
   } sgdma_sel_e;

   localparam int unsigned DIR_BIT = 15;
endpackage

// File: rtl/sgdma_page_table.sv
module sgdma_page_table #(
   parameter int unsigned ENTRY_W        = 16,
   parameter int unsigned NUM_PAGES      = 256,
   parameter bit          CLEAR_ON_RESET = 1'b1,
   parameter int unsigned IDX_W          = $clog2(NUM_PAGES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic [IDX_W-1:0]   rd_idx_a,
   output logic [ENTRY_W-1:0] rd_data_a,
   input  logic [IDX_W-1:0]   rd_idx_b,
   output logic [ENTRY_W-1:0] rd_data_b
);
   logic [ENTRY_W-1:0] mem [NUM_PAGES];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < NUM_PAGES; i++) mem[i] <= '0;
            end else if (wr_en) begin
               mem[wr_idx] <= wr_data;
            end
         end
      end else begin : g_noclear
         always_ff @(posedge clk) begin
            if (wr_en) mem[wr_idx] <= wr_data;
         end
      end
   endgenerate

   assign rd_data_a = mem[rd_idx_a];
   assign rd_data_b = mem[rd_idx_b];
endmodule

// File: rtl/sgdma_cursor.sv
module sgdma_cursor #(
   parameter int unsigned ENTRY_W   = 16,
   parameter int unsigned OFFS_W    = 12,
   parameter int unsigned NUM_PAGES = 256,
   parameter int unsigned IDX_W     = $clog2(NUM_PAGES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               disarm,
   input  logic               arm,
   input  logic [OFFS_W-1:0]  start_off,
   input  logic               adv,
   input  logic [ENTRY_W-1:0] next_page,
   output logic [ENTRY_W-1:0] page_q,
   output logic [OFFS_W-1:0]  off_q,
   output logic [IDX_W-1:0]   idx_q,
   output logic               active,
   output logic               overrun_q
);
   localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_PAGES - 1);
   localparam logic [OFFS_W-1:0] OFF_MAX  = '1;

   logic armed_q;
   logic step;

   assign active = armed_q & ~overrun_q;
   assign step   = adv & active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q   <= 1'b0;
         overrun_q <= 1'b0;
         idx_q     <= '0;
         off_q     <= '0;
         page_q    <= '0;
      end else if (disarm) begin
         armed_q   <= 1'b0;
         overrun_q <= 1'b0;
         idx_q     <= '0;
         off_q     <= '0;
         page_q    <= '0;
      end else if (arm) begin
         armed_q   <= 1'b1;
         overrun_q <= 1'b0;
         idx_q     <= '0;
         off_q     <= start_off;
         page_q    <= next_page;
      end else if (step) begin
         if (off_q == OFF_MAX) begin
            if (idx_q == LAST_IDX) begin
               overrun_q <= 1'b1;
            end else begin
               idx_q  <= idx_q + 1'b1;
               off_q  <= '0;
               page_q <= next_page;
            end
         end else begin
            off_q <= off_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sg_dma_addr_gen.sv
module sg_dma_addr_gen #(
   parameter int unsigned       ENTRY_W        = 16,
   parameter int unsigned       OFFS_W         = 12,
   parameter int unsigned       NUM_PAGES      = 256,
   parameter int unsigned       DATA_W         = 32,
   parameter int unsigned       BUS_AW         = 12,
   parameter logic [BUS_AW-1:0] START_ADDR     = 12'h000,
   parameter logic [BUS_AW-1:0] FLUSH_ADDR     = 12'h004,
   parameter logic [BUS_AW-1:0] TBL_BASE       = 12'h400,
   parameter bit                CLEAR_ON_RESET = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_we,
   input  logic [BUS_AW-1:0]         bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   output logic [DATA_W-1:0]         bus_rdata,
   input  logic                      adv_req,
   output logic                      dma_valid,
   output logic [ENTRY_W+OFFS_W-1:0] dma_addr,
   output logic                      dma_dir,
   output logic                      overrun
);
   import sgdma_pkg::*;

   localparam int unsigned IDX_W  = $clog2(NUM_PAGES);
   localparam int unsigned SPAN_W = IDX_W + 2;

   generate
      if (NUM_PAGES < 2 || (NUM_PAGES & (NUM_PAGES - 1)) != 0) begin : g_bad_pages
         $error("NUM_PAGES must be a power of two of at least 2");
      end
      if (OFFS_W < 1 || OFFS_W > DIR_BIT) begin : g_bad_offs
         $error("OFFS_W must lie between 1 and the direction bit position");
      end
      if (DATA_W < ENTRY_W || DATA_W <= DIR_BIT) begin : g_bad_data
         $error("DATA_W too narrow for page entries or the start register");
      end
      if (BUS_AW <= SPAN_W) begin : g_bad_aw
         $error("BUS_AW too narrow for the page table region");
      end
      if ((int'(TBL_BASE) % (4 * NUM_PAGES)) != 0) begin : g_bad_base
         $error("TBL_BASE must be aligned to the table span");
      end
   endgenerate

   sgdma_sel_e         sel;
   logic [IDX_W-1:0]   bus_idx;
   logic               dir_q;
   logic [OFFS_W-1:0]  start_q;
   logic               arm, disarm;
   logic [ENTRY_W-1:0] tbl_rd_a, tbl_rd_b;
   logic [IDX_W-1:0]   idx_q, nxt_idx;
   logic [ENTRY_W-1:0] page_q;
   logic [OFFS_W-1:0]  off_q;
   logic               active;

   assign bus_idx = bus_addr[SPAN_W-1:2];

   always_comb begin
      sel = SEL_NONE;
      if (bus_addr == START_ADDR)
         sel = SEL_START;
      else if (bus_addr == FLUSH_ADDR)
         sel = SEL_FLUSH;
      else if (bus_addr[BUS_AW-1:SPAN_W] == TBL_BASE[BUS_AW-1:SPAN_W] && bus_addr[1:0] == 2'b00)
         sel = SEL_PAGE;
   end

   assign arm    = bus_we && sel == SEL_START;
   assign disarm = bus_we && sel == SEL_FLUSH && bus_wdata == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= 1'b0;
         start_q <= '0;
      end else if (arm) begin
         dir_q   <= bus_wdata[DIR_BIT];
         start_q <= bus_wdata[OFFS_W-1:0];
      end
   end

   assign nxt_idx = arm ? '0 : idx_q + 1'b1;

   sgdma_page_table #(
      .ENTRY_W(ENTRY_W), .NUM_PAGES(NUM_PAGES),
      .CLEAR_ON_RESET(CLEAR_ON_RESET), .IDX_W(IDX_W)
   ) table_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_we && sel == SEL_PAGE), .wr_idx(bus_idx),
      .wr_data(bus_wdata[ENTRY_W-1:0]),
      .rd_idx_a(bus_idx), .rd_data_a(tbl_rd_a),
      .rd_idx_b(nxt_idx), .rd_data_b(tbl_rd_b)
   );

   sgdma_cursor #(
      .ENTRY_W(ENTRY_W), .OFFS_W(OFFS_W),
      .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)
   ) cursor_i (
      .clk(clk), .rst_n(rst_n),
      .disarm(disarm), .arm(arm), .start_off(bus_wdata[OFFS_W-1:0]),
      .adv(adv_req), .next_page(tbl_rd_b),
      .page_q(page_q), .off_q(off_q), .idx_q(idx_q),
      .active(active), .overrun_q(overrun)
   );

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_START: begin
            bus_rdata[DIR_BIT]    = dir_q;
            bus_rdata[OFFS_W-1:0] = start_q;
         end
         SEL_PAGE:  bus_rdata[ENTRY_W-1:0] = tbl_rd_a;
         default:   bus_rdata = '0;
      endcase
   end

   assign dma_valid = adv_req & active;
   assign dma_addr  = {page_q, off_q};
   assign dma_dir   = dir_q;
endmodule

// File: rtl/sgdma_checker.sv
module sgdma_checker #(
   parameter int unsigned       OFFS_W     = 12,
   parameter int unsigned       ADDR_W     = 28,
   parameter int unsigned       DATA_W     = 32,
   parameter int unsigned       BUS_AW     = 12,
   parameter logic [BUS_AW-1:0] START_ADDR = 12'h000,
   parameter logic [BUS_AW-1:0] FLUSH_ADDR = 12'h004
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [BUS_AW-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              adv_req,
   input logic              dma_valid,
   input logic [ADDR_W-1:0] dma_addr,
   input logic              dma_dir,
   input logic              overrun
);
   localparam logic [OFFS_W-1:0] OFF_MAX = '1;

   assert_valid_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dma_valid |-> adv_req);

   assert_offset_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_valid && !bus_we && dma_addr[OFFS_W-1:0] != OFF_MAX) |=>
      (dma_addr[OFFS_W-1:0] == $past(dma_addr[OFFS_W-1:0]) + 1'b1) &&
      (dma_addr[ADDR_W-1:OFFS_W] == $past(dma_addr[ADDR_W-1:OFFS_W])));

   assert_page_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_valid && !bus_we && dma_addr[OFFS_W-1:0] == OFF_MAX) |=>
      (dma_addr[OFFS_W-1:0] == '0 || overrun));

   assert_hold_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!dma_valid && !bus_we) |=> ($stable(dma_addr) && $stable(dma_dir)));

   assert_arm_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == START_ADDR) |=>
      (dma_addr[OFFS_W-1:0] == $past(bus_wdata[OFFS_W-1:0]) &&
       dma_dir == $past(bus_wdata[15]) && !overrun));

   assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !bus_we) |=> overrun);

   assert_overrun_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> !dma_valid);

   assert_flush_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == FLUSH_ADDR && bus_wdata == '0) |=>
      (!overrun && !dma_valid && dma_addr == '0));
endmodule

bind sg_dma_addr_gen sgdma_checker #(
   .OFFS_W(OFFS_W), .ADDR_W(ENTRY_W + OFFS_W), .DATA_W(DATA_W),
   .BUS_AW(BUS_AW), .START_ADDR(START_ADDR), .FLUSH_ADDR(FLUSH_ADDR)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .adv_req(adv_req), .dma_valid(dma_valid),
   .dma_addr(dma_addr), .dma_dir(dma_dir), .overrun(overrun)
);

// File: tb/sg_dma_addr_gen_tb_top.sv
module sg_dma_addr_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NPG        = 16;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        adv_req = 1'b0;
   logic        dma_valid;
   logic [27:0] dma_addr;
   logic        dma_dir;
   logic        overrun;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sg_dma_addr_gen #(.NUM_PAGES(NPG)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adv_req(adv_req),
      .dma_valid(dma_valid), .dma_addr(dma_addr), .dma_dir(dma_dir),
      .overrun(overrun)
   );

   function automatic logic [15:0] pat(int i);
      return 16'h5A00 ^ 16'(i * 16'h0B37);
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      #1;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      adv_req = 1'b1;
      #1;
      chk("R1", "valid", 32'(dma_valid), 0);
      chk("R1", "overrun", 32'(overrun), 0);
      chk("R1", "addr/dir", {3'b0, dma_dir, dma_addr}, 0);
      adv_req = 1'b0;
      rd(12'h40C, d);
      chk("R1", "entry3", d, 0);
   endtask

   task automatic t_table;
      logic [31:0] d;
      int bad = 0;
      for (int i = 0; i < NPG; i++) wr(12'h400 + 12'(4 * i), {16'hDEAD, pat(i)});
      for (int i = 0; i < NPG; i++) begin
         rd(12'h400 + 12'(4 * i), d);
         if (d !== {16'h0, pat(i)}) bad++;
      end
      chk("R3", "readback mismatches", bad, 0);
      wr(12'h402, 32'h0000_1234);
      rd(12'h400, d);
      chk("R3", "misaligned write ignored", d, {16'h0, pat(0)});
   endtask

   task automatic t_start;
      logic [31:0] d;
      wr(12'h000, 32'h0000_F123);
      rd(12'h000, d);
      chk("R2", "start readback", d, 32'h0000_8123);
      chk("R2", "dir", 32'(dma_dir), 1);
      chk("R2", "first addr", 32'(dma_addr), {4'h0, pat(0), 12'h123});
      chk("R5", "no req no valid", 32'(dma_valid), 0);
   endtask

   task automatic t_step;
      logic [27:0] a0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk); adv_req = 1'b1; #1;
         chk("R5", "valid with req", 32'(dma_valid), 1);
         chk("R4", "addr", 32'(dma_addr), {4'h0, pat(0), 12'(12'h123 + k)});
      end
      @(negedge clk); adv_req = 1'b0; #1;
      a0 = dma_addr;
      repeat (3) @(negedge clk);
      #1;
      chk("R5", "addr held", 32'(dma_addr), 32'(a0));
      chk("R5", "addr after steps", 32'(a0), {4'h0, pat(0), 12'h128});
   endtask

   task automatic t_wrap;
      wr(12'h000, 32'h0000_0FFD);
      chk("R2", "dir clear", 32'(dma_dir), 0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); adv_req = 1'b1; #1;
         chk("R6", "before wrap", 32'(dma_addr), {4'h0, pat(0), 12'(12'hFFD + k)});
      end
      for (int k = 0; k < 2; k++) begin
         @(negedge clk); adv_req = 1'b1; #1;
         chk("R6", "next page from zero", 32'(dma_addr), {4'h0, pat(1), 12'(k)});
      end
      @(negedge clk); adv_req = 1'b0;
   endtask

   task automatic t_overrun;
      int bad = 0;
      wr(12'h000, 32'h0000_8FFF);
      for (int p = 0; p < NPG; p++) begin
         for (int o = (p == 0) ? 12'hFFF : 0; o < 4096; o++) begin
            @(negedge clk); adv_req = 1'b1; #1;
            if (dma_valid !== 1'b1 || dma_addr !== {pat(p), 12'(o)}) bad++;
         end
      end
      chk("R7", "walk mismatches", bad, 0);
      @(negedge clk); #1;
      chk("R7", "overrun set", 32'(overrun), 1);
      chk("R7", "valid blocked", 32'(dma_valid), 0);
      chk("R7", "addr held", 32'(dma_addr), {4'h0, pat(NPG - 1), 12'hFFF});
      @(negedge clk); adv_req = 1'b0;
   endtask

   task automatic t_flush;
      wr(12'h004, 32'h0000_0001);
      chk("R8", "nonzero flush ignored", 32'(overrun), 1);
      wr(12'h004, 32'h0);
      adv_req = 1'b1; #1;
      chk("R8", "overrun cleared", 32'(overrun), 0);
      chk("R8", "disarmed", 32'(dma_valid), 0);
      chk("R8", "addr zero", 32'(dma_addr), 0);
      adv_req = 1'b0;
      wr(12'h000, 32'h0000_0010);
      adv_req = 1'b1; #1;
      chk("R2", "rearm after flush", {3'b0, dma_valid, dma_addr}, {4'h1, pat(0), 12'h010});
      @(negedge clk); adv_req = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_table();
      t_start();
      t_step();
      t_wrap();
      t_overrun();
      t_flush();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule